// File: doc/BRIEF.md
# Asynchronous SRAM Access Timing Monitor

This block watches the control, address and data pins of an asynchronous 16-bit static RAM that has separate low-byte and high-byte enables. It takes no part in the traffic. A fast monitor clock samples the pins. The pins must already be synchronous to that clock, or be driven from it in a testbench. Each sample is classified into one access mode. Write windows are tracked, and each one is labelled by the strobe that opened it. Strobe widths, data setup, address stability and access cycle length are measured in monitor-clock samples. Each measured value is compared against a parameterised minimum.

The first check that fails is reported through a sticky flag and a 4-bit code. The code stays in place until the synchronous clear input is pulsed. Completed read windows and completed write windows are counted by two saturating counters. The block suits self-checking benches and on-chip debugging of an external memory bus.

All outputs are registered. A pin sample taken at clock edge k shows on the outputs just after edge k.

Top module: `sram_timing_monitor`

## Requirements
- R1: `mode` shows the sample's access class with this encoding:
  - 0 when chip select is high.
  - 1 when both byte enables are high, or when write and output enables are both high.
  - 2, 3 and 4 for a low-byte, high-byte or both-byte write. Write enable is low in all three.
  - 5, 6 and 7 for a low-byte, high-byte or both-byte read. Write enable is high and output enable is low.
- R2: A write window covers every consecutive sample in which chip select, write enable and at least one byte enable are all active. `wr_count` advances by one on the first sample after each window ends.
- R3: `wr_kind` gives the strobe that completed the set of active signals when the latest window opened: 1 for chip select, 2 for write enable, 3 for byte enable. When several become active in the same sample, chip select ranks above write enable, and write enable ranks above byte enable.
- R4: A window shorter than the minimum for its kind is a violation. The minimums are T_CW for chip select, T_WP for write enable and T_BW for byte enable. The codes are 2, 3 and 4 respectively.
- R5: Data must stay unchanged for at least T_DS samples, ending with the last sample of the window. Otherwise code 5 is raised.
- R6: An address change between two samples that both lie inside a write window raises code 1.
- R7: The samples between two address changes form one address period. At each address change the period just ended is checked:
  - If it held a write sample and lasted fewer than T_WC samples, code 6 is raised.
  - If it held a read sample but no write sample and lasted fewer than T_RC samples, code 7 is raised.
- R8: Code 8 is raised when write enable falls while chip select is low, the address is unchanged, and the current address period already holds a read sample.
- R9: When several checks fail in the same sample, the lowest code is the one reported.
- R10: `err_flag` and `err_code` are 0 after reset. A violation sets the flag. The code is loaded only if the flag was clear, so a later violation never overwrites it. `clr` clears both, and a clear takes precedence over a violation in the same sample.
- R11: `rd_count` advances once when a read window ends, meaning the first sample that is no longer a read. Both counters are 0 after reset and hold at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of error flag and code |
| cs_n | input | 1 | Observed chip select, active low |
| we_n | input | 1 | Observed write enable, active low |
| oe_n | input | 1 | Observed output enable, active low |
| lb_n | input | 1 | Observed low-byte enable, active low |
| ub_n | input | 1 | Observed high-byte enable, active low |
| addr | input | ADDR_W | Observed address bus |
| dq_in | input | DATA_W | Observed data bus |
| mode | output | 3 | Access class of the latest sample |
| wr_kind | output | 2 | Strobe kind of the latest write window |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| rd_count | output | COUNT_W | Completed read windows, saturating |
| wr_count | output | COUNT_W | Completed write windows, saturating |

## Verification
The hardest situation to reach is one sample that both moves the address inside an open window and ends a write period that is too short. Only that overlap exercises the priority between codes 1 and 6. The stimulus creates it by opening a write-enable window, then moving the address a few samples later while the window is still open.

Code stickiness is harder to observe than a single failure. To exercise it, a short-read violation is staged right after a short write pulse, before any clear, and the bench confirms that the first code survives. A behavioural timestamp model runs beside the design on every clock and predicts the flag, code, counters, mode and kind.

// File: rtl/sram_mon_pkg.sv
`timescale 1ns/1ps
package sram_mon_pkg;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_OFF    = 3'd1,
    M_WR_LO  = 3'd2,
    M_WR_HI  = 3'd3,
    M_WR_ALL = 3'd4,
    M_RD_LO  = 3'd5,
    M_RD_HI  = 3'd6,
    M_RD_ALL = 3'd7
  } acc_mode_t;

  typedef enum logic [1:0] {
    K_NONE    = 2'd0,
    K_CHIPSEL = 2'd1,
    K_WRSTB   = 2'd2,
    K_BYTE    = 2'd3
  } wr_kind_t;

  typedef enum logic [3:0] {
    E_NONE       = 4'd0,
    E_ADDR_MOVE  = 4'd1,
    E_CS_WIDTH   = 4'd2,
    E_WE_WIDTH   = 4'd3,
    E_BE_WIDTH   = 4'd4,
    E_DATA_SETUP = 4'd5,
    E_WR_CYCLE   = 4'd6,
    E_RD_CYCLE   = 4'd7,
    E_WE_IN_READ = 4'd8
  } err_code_t;

  localparam int unsigned NUM_CHECKS = 8;

endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
  import sram_mon_pkg::*;
(
  input  logic      cs_n,
  input  logic      we_n,
  input  logic      oe_n,
  input  logic      lb_n,
  input  logic      ub_n,
  output acc_mode_t mode,
  output logic      be_act,
  output logic      wr_act,
  output logic      rd_act
);

  logic [1:0] lane;

  always_comb begin
    be_act = ~lb_n | ~ub_n;
    wr_act = ~cs_n & ~we_n & be_act;
    rd_act = ~cs_n & we_n & ~oe_n & be_act;
    // lane 0: low byte only, 1: high byte only, 2: both bytes
    case ({lb_n, ub_n})
      2'b01:   lane = 2'd0;
      2'b10:   lane = 2'd1;
      default: lane = 2'd2;
    endcase
    if (cs_n)               mode = M_IDLE;
    else if (!be_act)       mode = M_OFF;
    else if (!we_n)         mode = acc_mode_t'(3'd2 + {1'b0, lane});
    else if (!oe_n)         mode = acc_mode_t'(3'd5 + {1'b0, lane});
    else                    mode = M_OFF;
  end

endmodule

// File: rtl/sram_write_tracker.sv
`timescale 1ns/1ps
module sram_write_tracker
  import sram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned T_CW   = 15,
  parameter int unsigned T_WP   = 14,
  parameter int unsigned T_BW   = 15,
  parameter int unsigned T_DS   = 9
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              wr_act,
  input  logic              prv_cs_n,
  input  logic              prv_we_n,
  input  logic              prv_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prv_addr,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] prv_data,
  output wr_kind_t          kind,
  output logic              close,
  output logic              v_move,
  output logic              v_cs,
  output logic              v_we,
  output logic              v_be,
  output logic              v_setup
);

  localparam logic [CNT_W-1:0] LIM_CW = CNT_W'(T_CW);
  localparam logic [CNT_W-1:0] LIM_WP = CNT_W'(T_WP);
  localparam logic [CNT_W-1:0] LIM_BW = CNT_W'(T_BW);
  localparam logic [CNT_W-1:0] LIM_DS = CNT_W'(T_DS);

  logic             win_open;
  logic             short_win;
  wr_kind_t         kind_q, kind_d;
  logic [CNT_W-1:0] wid_q, wid_d, dsu_q, dsu_d, lim;

  always_comb begin
    win_open = wr_act & ~prv_wr;
    close    = ~wr_act & prv_wr;
    kind_d   = kind_q;
    wid_d    = wid_q;
    if (win_open) begin
      wid_d = CNT_W'(1);
      if (~cs_n & prv_cs_n)      kind_d = K_CHIPSEL;
      else if (~we_n & prv_we_n) kind_d = K_WRSTB;
      else                       kind_d = K_BYTE;
    end else if (wr_act && wid_q != '1) begin
      wid_d = wid_q + 1'b1;
    end
    if (data != prv_data)  dsu_d = CNT_W'(1);
    else if (dsu_q != '1)  dsu_d = dsu_q + 1'b1;
    else                   dsu_d = dsu_q;
    case (kind_q)
      K_CHIPSEL: lim = LIM_CW;
      K_WRSTB:   lim = LIM_WP;
      default:   lim = LIM_BW;
    endcase
    short_win = close & (wid_q < lim);
    v_cs      = short_win & (kind_q == K_CHIPSEL);
    v_we      = short_win & (kind_q == K_WRSTB);
    v_be      = short_win & (kind_q == K_BYTE);
    v_setup   = close & (dsu_q < LIM_DS);
    v_move    = wr_act & prv_wr & (addr != prv_addr);
    kind      = kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_NONE;
      wid_q  <= '0;
      dsu_q  <= '0;
    end else begin
      kind_q <= kind_d;
      wid_q  <= wid_d;
      dsu_q  <= dsu_d;
    end
  end

  a_r3_kind_named: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> kind_q != K_NONE);
  a_r2_width_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> wid_q == CNT_W'(1));

endmodule

// File: rtl/sram_cycle_tracker.sv
`timescale 1ns/1ps
module sram_cycle_tracker
  import sram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned T_WC   = 18,
  parameter int unsigned T_RC   = 18
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              prv_we_n,
  input  logic              rd_act,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prv_addr,
  output logic              rd_done,
  output logic              v_wc,
  output logic              v_rc,
  output logic              v_we_rd
);

  localparam logic [CNT_W-1:0] LIM_WC = CNT_W'(T_WC);
  localparam logic [CNT_W-1:0] LIM_RC = CNT_W'(T_RC);

  logic             addr_chg;
  logic             rd_q;
  logic             seen_rd_q, seen_rd_d, seen_wr_q, seen_wr_d;
  logic [CNT_W-1:0] per_q, per_d;

  always_comb begin
    addr_chg  = addr != prv_addr;
    rd_done   = rd_q & ~rd_act;
    v_wc      = addr_chg & seen_wr_q & (per_q < LIM_WC);
    v_rc      = addr_chg & ~seen_wr_q & seen_rd_q & (per_q < LIM_RC);
    v_we_rd   = ~addr_chg & ~cs_n & ~we_n & prv_we_n & seen_rd_q;
    seen_rd_d = (seen_rd_q & ~addr_chg) | rd_act;
    seen_wr_d = (seen_wr_q & ~addr_chg) | wr_act;
    if (addr_chg)          per_d = CNT_W'(1);
    else if (per_q != '1)  per_d = per_q + 1'b1;
    else                   per_d = per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      seen_rd_q <= 1'b0;
      seen_wr_q <= 1'b0;
      per_q     <= '0;
    end else begin
      rd_q      <= rd_act;
      seen_rd_q <= seen_rd_d;
      seen_wr_q <= seen_wr_d;
      per_q     <= per_d;
    end
  end

  a_r7_period_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> per_q == CNT_W'(1));
  a_r8_read_remembered: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |=> seen_rd_q);

endmodule

// File: rtl/sram_timing_monitor.sv
`timescale 1ns/1ps
module sram_timing_monitor
  import sram_mon_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned COUNT_W = 16,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned T_WC    = 18,
  parameter int unsigned T_CW    = 15,
  parameter int unsigned T_WP    = 14,
  parameter int unsigned T_BW    = 15,
  parameter int unsigned T_DS    = 9,
  parameter int unsigned T_RC    = 18
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               lb_n,
  input  logic               ub_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  dq_in,
  output logic [2:0]         mode,
  output logic [1:0]         wr_kind,
  output logic               err_flag,
  output logic [3:0]         err_code,
  output logic [COUNT_W-1:0] rd_count,
  output logic [COUNT_W-1:0] wr_count
);

  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  acc_mode_t dec_mode, mode_q;
  logic      be_act, wr_act, rd_act;

  sram_mode_decode u_dec (
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n),
    .mode(dec_mode), .be_act(be_act), .wr_act(wr_act), .rd_act(rd_act)
  );

  logic              prv_cs_n, prv_we_n, prv_wr;
  logic [ADDR_W-1:0] prv_addr;
  logic [DATA_W-1:0] prv_data;

  wr_kind_t kind;
  logic     wr_done, rd_done;
  logic     v_move, v_cs, v_we, v_be, v_setup, v_wc, v_rc, v_we_rd;

  sram_write_tracker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .T_CW(T_CW), .T_WP(T_WP), .T_BW(T_BW), .T_DS(T_DS)
  ) u_wr (
    .clk(clk), .rst_n(srst_n), .cs_n(cs_n), .we_n(we_n), .wr_act(wr_act),
    .prv_cs_n(prv_cs_n), .prv_we_n(prv_we_n), .prv_wr(prv_wr),
    .addr(addr), .prv_addr(prv_addr), .data(dq_in), .prv_data(prv_data),
    .kind(kind), .close(wr_done), .v_move(v_move), .v_cs(v_cs),
    .v_we(v_we), .v_be(v_be), .v_setup(v_setup)
  );

  sram_cycle_tracker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .T_WC(T_WC), .T_RC(T_RC)
  ) u_cyc (
    .clk(clk), .rst_n(srst_n), .cs_n(cs_n), .we_n(we_n), .prv_we_n(prv_we_n),
    .rd_act(rd_act), .wr_act(wr_act), .addr(addr), .prv_addr(prv_addr),
    .rd_done(rd_done), .v_wc(v_wc), .v_rc(v_rc), .v_we_rd(v_we_rd)
  );

  // bit i of viol corresponds to error code i+1
  logic [NUM_CHECKS-1:0] viol;
  err_code_t             first_code, err_code_q, err_code_d;
  logic                  err_flag_q, err_flag_d;
  logic [COUNT_W-1:0]    rd_cnt_q, rd_cnt_d, wr_cnt_q, wr_cnt_d;

  always_comb begin
    viol = {v_we_rd, v_rc, v_wc, v_setup, v_be, v_we, v_cs, v_move};
    first_code = E_NONE;
    for (int i = NUM_CHECKS - 1; i >= 0; i--) begin
      if (viol[i]) first_code = err_code_t'(4'(i + 1));
    end
    err_flag_d = err_flag_q;
    err_code_d = err_code_q;
    if (clr) begin
      err_flag_d = 1'b0;
      err_code_d = E_NONE;
    end else if (|viol) begin
      err_flag_d = 1'b1;
      if (!err_flag_q) err_code_d = first_code;
    end
    rd_cnt_d = (rd_done && rd_cnt_q != '1) ? rd_cnt_q + 1'b1 : rd_cnt_q;
    wr_cnt_d = (wr_done && wr_cnt_q != '1) ? wr_cnt_q + 1'b1 : wr_cnt_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prv_cs_n   <= 1'b1;
      prv_we_n   <= 1'b1;
      prv_wr     <= 1'b0;
      prv_addr   <= '0;
      prv_data   <= '0;
      mode_q     <= M_IDLE;
      err_flag_q <= 1'b0;
      err_code_q <= E_NONE;
      rd_cnt_q   <= '0;
      wr_cnt_q   <= '0;
    end else begin
      prv_cs_n   <= cs_n;
      prv_we_n   <= we_n;
      prv_wr     <= wr_act;
      prv_addr   <= addr;
      prv_data   <= dq_in;
      mode_q     <= dec_mode;
      err_flag_q <= err_flag_d;
      err_code_q <= err_code_d;
      rd_cnt_q   <= rd_cnt_d;
      wr_cnt_q   <= wr_cnt_d;
    end
  end

  assign mode     = mode_q;
  assign wr_kind  = kind;
  assign err_flag = err_flag_q;
  assign err_code = err_code_q;
  assign rd_count = rd_cnt_q;
  assign wr_count = wr_cnt_q;

  a_r10_code_held: assert property (@(posedge clk) disable iff (!srst_n)
    (err_flag_q && !clr) |=> err_code_q == $past(err_code_q));
  a_r10_code_needs_flag: assert property (@(posedge clk) disable iff (!srst_n)
    (err_code_q != E_NONE) |-> err_flag_q);
  a_r11_wr_saturates: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_cnt_q == '1) |=> wr_cnt_q == '1);
  a_r11_rd_saturates: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_cnt_q == '1) |=> rd_cnt_q == '1);

endmodule

// File: tb/sram_timing_monitor_test.sv
`timescale 1ns/1ps
module sram_timing_monitor_test;

  localparam int CW_T = 4;
  localparam int TWC = 18, TCW = 15, TWP = 14, TBW = 15, TDS = 9, TRC = 18;
  localparam int SATV = (1 << CW_T) - 1;

  logic clk = 1'b0;
  logic rst_n, clr, cs_n, we_n, oe_n, lb_n, ub_n;
  logic [17:0] addr;
  logic [15:0] dq;
  logic [2:0]  mode;
  logic [1:0]  wr_kind;
  logic        err_flag;
  logic [3:0]  err_code;
  logic [CW_T-1:0] rd_count, wr_count;

  always #2 clk = ~clk;

  sram_timing_monitor #(
    .ADDR_W(18), .DATA_W(16), .COUNT_W(CW_T), .CNT_W(8),
    .T_WC(TWC), .T_CW(TCW), .T_WP(TWP), .T_BW(TBW), .T_DS(TDS), .T_RC(TRC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .dq_in(dq), .mode(mode),
    .wr_kind(wr_kind), .err_flag(err_flag), .err_code(err_code),
    .rd_count(rd_count), .wr_count(wr_count)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // timestamp-based reference state
  int n = 1;
  bit m_cs = 1, m_we = 1, m_wact = 0, m_rd = 0, s_rd = 0, s_wr = 0;
  logic [17:0] m_addr = '0;
  logic [15:0] m_data = '0;
  int t_addr = 0, t_data = 0, t_open = 0, e_kind = 0;
  int e_flag = 0, e_code = 0, e_rc = 0, e_wc = 0, e_mode = 0;

  task automatic chk(string req, string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0d expected %0d at t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int pick(int cur, int c);
    return (cur == 0 || c < cur) ? c : cur;
  endfunction

  task automatic model_step();
    bit be, wact, rd, chg;
    int cand, lim, lane;
    be   = !lb_n || !ub_n;
    wact = !cs_n && !we_n && be;
    rd   = !cs_n && we_n && !oe_n && be;
    chg  = (addr != m_addr);
    cand = 0;
    if (m_wact && wact && chg) cand = pick(cand, 1);
    if (m_wact && !wact) begin
      lim = (e_kind == 1) ? TCW : (e_kind == 2) ? TWP : TBW;
      if (n - t_open < lim) cand = pick(cand, e_kind + 1);
      if (n - t_data < TDS) cand = pick(cand, 5);
      if (e_wc < SATV) e_wc++;
    end
    if (chg) begin
      if (s_wr && (n - t_addr) < TWC) cand = pick(cand, 6);
      else if (!s_wr && s_rd && (n - t_addr) < TRC) cand = pick(cand, 7);
    end
    if (!chg && !cs_n && !we_n && m_we && s_rd) cand = pick(cand, 8);
    if (m_rd && !rd && e_rc < SATV) e_rc++;
    if (chg) begin t_addr = n; s_rd = 0; s_wr = 0; end
    s_rd |= rd; s_wr |= wact;
    if (wact && !m_wact) begin
      t_open = n;
      e_kind = (!cs_n && m_cs) ? 1 : (!we_n && m_we) ? 2 : 3;
    end
    if (dq != m_data) t_data = n;
    if (clr) begin e_flag = 0; e_code = 0; end
    else if (cand != 0) begin
      if (e_flag == 0) e_code = cand;
      e_flag = 1;
    end
    lane = (!lb_n && ub_n) ? 0 : (lb_n && !ub_n) ? 1 : 2;
    if (cs_n) e_mode = 0;
    else if (!be) e_mode = 1;
    else if (!we_n) e_mode = 2 + lane;
    else if (!oe_n) e_mode = 5 + lane;
    else e_mode = 1;
    m_cs = cs_n; m_we = we_n; m_wact = wact; m_rd = rd;
    m_addr = addr; m_data = dq;
    n++;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    model_step();
    chk("R1", "mode", int'(mode), e_mode);
    chk("R3", "wr_kind", int'(wr_kind), e_kind);
    chk("R10", "err_flag", int'(err_flag), e_flag);
    chk("R9", "err_code", int'(err_code), e_code);
    chk("R11", "rd_count", int'(rd_count), e_rc);
    chk("R2", "wr_count", int'(wr_count), e_wc);
  endtask

  task automatic tick(int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic wr_we(logic [17:0] a, logic [15:0] d, int width, int tail);
    addr = a; dq = d; cs_n = 0; oe_n = 1; lb_n = 0; ub_n = 0; we_n = 1;
    tick(3);
    we_n = 0; tick(width);
    we_n = 1; tick(tail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired (all requirements)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; cs_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1;
    addr = '0; dq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // reset state
    chk("R10", "reset err_flag", int'(err_flag), 0);
    chk("R10", "reset err_code", int'(err_code), 0);
    chk("R11", "reset wr_count", int'(wr_count), 0);
    chk("R1", "reset mode", int'(mode), 0);

    // R2/R1: clean write-enable controlled both-byte write
    addr = 18'h100; dq = 16'h1234; cs_n = 0; lb_n = 0; ub_n = 0; tick(3);
    we_n = 0; tick(15);
    chk("R1", "mode both-byte write", int'(mode), 4);
    we_n = 1; tick(3);
    chk("R2", "write counted", int'(wr_count), 1);
    chk("R3", "we-controlled kind", int'(wr_kind), 2);
    chk("R4", "clean write no error", int'(err_flag), 0);

    // R1/R11: clean low-byte read
    addr = 18'h101; oe_n = 0; ub_n = 1; tick(20);
    chk("R1", "mode low-byte read", int'(mode), 5);
    oe_n = 1; tick(2);
    chk("R11", "read counted", int'(rd_count), 1);

    // R4: short chip-select controlled write
    addr = 18'h200; dq = 16'h0F0F; we_n = 0; cs_n = 1; lb_n = 0; ub_n = 1; tick(12);
    cs_n = 0; tick(10);
    cs_n = 1; tick(12);
    chk("R4", "cs width code", int'(err_code), 2);
    chk("R3", "cs-controlled kind", int'(wr_kind), 1);
    pulse_clr();
    chk("R10", "flag cleared", int'(err_flag), 0);

    // R5: byte-enable controlled write with late data
    addr = 18'h300; dq = 16'hAAAA; cs_n = 0; we_n = 0; lb_n = 1; ub_n = 1; tick(4);
    lb_n = 0; tick(12);
    dq = 16'h5555; tick(5);
    lb_n = 1; tick(10);
    chk("R5", "data setup code", int'(err_code), 5);
    chk("R3", "byte-controlled kind", int'(wr_kind), 3);
    pulse_clr();

    // R4/R10: short write pulse then a short read; first code must stay
    addr = 18'h400; dq = 16'h0044; we_n = 1; oe_n = 1; lb_n = 0; ub_n = 0; tick(3);
    we_n = 0; tick(8);
    we_n = 1; tick(10);
    chk("R4", "we width code", int'(err_code), 3);
    addr = 18'h401; oe_n = 0; tick(5);
    addr = 18'h402; tick(3);
    chk("R10", "code kept after second violation", int'(err_code), 3);
    chk("R10", "flag still set", int'(err_flag), 1);
    oe_n = 1; pulse_clr();
    chk("R10", "code cleared", int'(err_code), 0);
    tick(20);

    // R6/R9: address moves inside window, same sample ends a short write period
    addr = 18'h500; dq = 16'h0055; tick(3);
    we_n = 0; tick(6);
    addr = 18'h501; tick(10);
    we_n = 1; tick(20);
    chk("R6", "address move code wins", int'(err_code), 1);
    pulse_clr();

    // R7: read period too short
    addr = 18'h600; oe_n = 0; tick(20);
    addr = 18'h601; tick(6);
    addr = 18'h602; tick(20);
    chk("R7", "read cycle code", int'(err_code), 7);
    pulse_clr();

    // R7: write period too short
    addr = 18'h700; oe_n = 1; dq = 16'h0077; tick(1);
    we_n = 0; tick(15);
    we_n = 1; addr = 18'h701; tick(20);
    chk("R7", "write cycle code", int'(err_code), 6);
    pulse_clr();

    // R8: write enable falls during a read period
    addr = 18'h800; oe_n = 0; lb_n = 0; ub_n = 1; tick(20);
    oe_n = 1; tick(1);
    we_n = 0; tick(16);
    we_n = 1; tick(5);
    chk("R8", "write enable in read code", int'(err_code), 8);
    pulse_clr();

    // R3: chip select and write enable fall together
    addr = 18'h900; cs_n = 1; we_n = 1; lb_n = 0; ub_n = 0; tick(3);
    cs_n = 0; we_n = 0; tick(16);
    cs_n = 1; we_n = 1; tick(5);
    chk("R3", "tie resolves to chip select", int'(wr_kind), 1);
    chk("R4", "tie write clean", int'(err_flag), 0);

    // R11: write counter saturation
    for (int i = 0; i < 12; i++) wr_we(18'hA00 + 18'(i), 16'(i), 15, 3);
    chk("R11", "write counter saturated", int'(wr_count), SATV);
    chk("R2", "clean writes no error", int'(err_flag), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule